// File: doc/BRIEF.md
# Circular Stage Window Allocator

This block keeps track of which instruction windows occupy a ring of identical execution stages. New windows arrive on a valid/ready handshake that carries a window identifier. Each one goes to the stage at the tail of the ring, so the ring always holds windows in program order, starting at the head stage.

Each stage reports back on two lines, one for completion and one for a branch misprediction. When the oldest window (the one at the head) reports completion, the block retires it. It pulses that stage's commit output and moves the head forward by one, wrapping around the ring.

When a stage reports a misprediction, every window younger than it is discarded. Each discarded stage gets a squash pulse, and the tail is pulled back to the stage just after the one that mispredicted. The execution stages read the per-stage valid, squash, commit and window-ID outputs to start, abandon or finish their work.

Top module: `swa_window_ring`

## Requirements
- R1: While reset is high and in the first cycle after it, all `stage_valid`, `stage_squash` and `stage_commit` bits are 0 and `alloc_ready` is 1.
- R2: When `alloc_valid` and `alloc_ready` are both high at a clock edge, the stage at index (head + occupancy) mod N becomes valid after that edge and presents `alloc_id` on its slice `stage_win_id[i*ID_W +: ID_W]`. Stages are filled in ring order starting from index 0 after reset.
- R3: `alloc_ready` is 0 whenever all N stages are valid. It is also 0 in any cycle where a valid stage raises `stage_mispredict`. A request that is not ready changes nothing.
- R4: A commit happens only when the head stage is valid and its `stage_done` bit is high at a clock edge. After that edge, `stage_commit` is one-hot on the head stage for one cycle, that stage's valid bit is 0, and the head moves to the next index, wrapping around. `stage_done` on any stage other than the head has no effect.
- R5: When no stage is valid, `stage_done` has no effect: `stage_commit` stays 0.
- R6: A valid mispredicting stage at relative position p from the head discards every valid stage at a relative position greater than p. After the edge, each discarded stage shows `stage_squash` high for exactly one cycle, with its valid bit already 0.
- R7: After a misprediction the tail sits just past the mispredicting stage, so the next accepted window lands on index (mispredicting stage + 1) mod N.
- R8: If several valid stages mispredict in the same cycle, the one nearest the head takes effect.
- R9: A head commit and a misprediction in the same cycle are both applied, with the commit first. The head advances, and the stages younger than the mispredicting one are squashed.
- R10: `stage_mispredict` on a stage whose valid bit is 0 has no effect: no squash pulse follows and occupancy is unchanged.
- R11: Head and tail wrap from index N-1 to index 0, so a ring that starts at a nonzero head can be filled to N windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | A new window is offered |
| alloc_id | input | ID_W | Identifier of the offered window |
| alloc_ready | output | 1 | The offered window is accepted this cycle |
| stage_done | input | N_STAGES | Per-stage completion report |
| stage_mispredict | input | N_STAGES | Per-stage branch misprediction report |
| stage_valid | output | N_STAGES | Stage holds a live window |
| stage_squash | output | N_STAGES | One-cycle discard pulse per stage |
| stage_commit | output | N_STAGES | One-cycle retire pulse per stage |
| stage_win_id | output | N_STAGES*ID_W | Window identifier held by each stage |

## Verification
`alloc_ready` is a combinational result of the current state and this cycle's mispredict inputs. The bench therefore reads it one time unit after driving the inputs, well before the next rising edge. Valid, commit, squash and window-ID outputs all come from one register stage, so their response to a stimulus is due in the cycle right after the edge that samples it. The bench drives inputs on the falling edge, lets the rising edge pass, and compares against its behavioural ring model at the following falling edge. Directed sequences put exact expected masks on the full-ring, wrap, priority and same-cycle commit-plus-mispredict cases. A long random phase then compares every output to the model on every cycle.

// File: rtl/swa_pkg.sv
package swa_pkg;

    // Per-stage command issued by the ring controller for one clock.
    typedef struct packed {
        logic alloc;   // stage receives a new window
        logic commit;  // stage retires its window
        logic squash;  // stage discards its window
    } slot_cmd_t;

    // Ring event classes, used for readable decode in the controller.
    typedef enum logic [1:0] {
        EV_IDLE     = 2'd0,
        EV_RETIRE   = 2'd1,
        EV_TRUNCATE = 2'd2,
        EV_BOTH     = 2'd3
    } ring_event_e;

    // Add two ring offsets, each below n, and wrap the sum into [0, n).
    function automatic int ring_step(input int a, input int b, input int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

    // Distance from base forward to idx around a ring of n entries.
    function automatic int ring_dist(input int base, input int idx, input int n);
        return ring_step(idx, n - base, n);
    endfunction

endpackage

// File: rtl/swa_oldest_pick.sv
module swa_oldest_pick #(
    parameter int N_STAGES = 8,
    localparam int IDX_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic [IDX_W-1:0]    head,
    input  logic [N_STAGES-1:0] req,
    output logic                any,
    output logic [IDX_W-1:0]    rel_pos
);
    import swa_pkg::*;

    logic [N_STAGES-1:0] rotated;

    // Rotate so that bit 0 is the head stage, bit k is k stages younger.
    always_comb begin
        for (int k = 0; k < N_STAGES; k++) begin
            rotated[k] = req[ring_step(int'(head), k, N_STAGES)];
        end
    end

    // Lowest rotated bit is the oldest requester.
    always_comb begin
        any     = |rotated;
        rel_pos = '0;
        for (int k = N_STAGES - 1; k >= 0; k--) begin
            if (rotated[k]) rel_pos = IDX_W'(k);
        end
    end

endmodule

// File: rtl/swa_ring_ctrl.sv
module swa_ring_ctrl #(
    parameter int N_STAGES = 8,
    localparam int IDX_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1,
    localparam int CNT_W = $clog2(N_STAGES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_valid,
    input  logic [N_STAGES-1:0]         stage_done,
    input  logic [N_STAGES-1:0]         stage_valid,
    input  logic                        mp_any,
    input  logic [IDX_W-1:0]            mp_pos,
    output logic [IDX_W-1:0]            head,
    output logic                        alloc_ready,
    output swa_pkg::slot_cmd_t [N_STAGES-1:0] cmd
);
    import swa_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_STAGES);

    logic [IDX_W-1:0] head_q, head_d, tail;
    logic [CNT_W-1:0] count_q, count_d, kept;
    logic             commit_fire, alloc_fire;
    ring_event_e      ev;

    assign head = head_q;

    always_comb begin
        commit_fire = (count_q != '0) && stage_done[head_q];
        alloc_ready = (count_q < FULL_CNT) && !mp_any;
        alloc_fire  = alloc_valid && alloc_ready;
        tail        = IDX_W'(ring_step(int'(head_q), int'(count_q), N_STAGES));
        ev          = ring_event_e'({mp_any, commit_fire});
    end

    // Occupancy update: truncate first (keeps head..mispredictor), then
    // retire the head, then append at the tail.
    always_comb begin
        unique case (ev)
            EV_TRUNCATE, EV_BOTH: kept = CNT_W'(mp_pos) + CNT_W'(1);
            default:              kept = count_q;
        endcase
        count_d = kept;
        if (commit_fire) count_d = count_d - CNT_W'(1);
        if (alloc_fire)  count_d = count_d + CNT_W'(1);
        head_d = commit_fire
               ? IDX_W'(ring_step(int'(head_q), 1, N_STAGES))
               : head_q;
    end

    always_comb begin
        for (int i = 0; i < N_STAGES; i++) begin
            cmd[i].alloc  = alloc_fire && (tail == IDX_W'(i));
            cmd[i].commit = commit_fire && (head_q == IDX_W'(i));
            cmd[i].squash = mp_any && stage_valid[i]
                && (ring_dist(int'(head_q), i, N_STAGES) > int'(mp_pos));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_d;
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/swa_stage_slot.sv
module swa_stage_slot #(
    parameter int ID_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  swa_pkg::slot_cmd_t cmd,
    input  logic [ID_W-1:0]    alloc_id,
    output logic               valid,
    output logic               squash,
    output logic               commit,
    output logic [ID_W-1:0]    win_id
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            squash <= 1'b0;
            commit <= 1'b0;
            win_id <= '0;
        end else begin
            squash <= cmd.squash;
            commit <= cmd.commit;
            if (cmd.alloc) begin
                valid  <= 1'b1;
                win_id <= alloc_id;
            end else if (cmd.commit || cmd.squash) begin
                valid  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/swa_window_ring.sv
module swa_window_ring #(
    parameter int N_STAGES = 8,
    parameter int ID_W     = 8,
    localparam int IDX_W   = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_valid,
    input  logic [ID_W-1:0]          alloc_id,
    output logic                     alloc_ready,
    input  logic [N_STAGES-1:0]      stage_done,
    input  logic [N_STAGES-1:0]      stage_mispredict,
    output logic [N_STAGES-1:0]      stage_valid,
    output logic [N_STAGES-1:0]      stage_squash,
    output logic [N_STAGES-1:0]      stage_commit,
    output logic [N_STAGES*ID_W-1:0] stage_win_id
);
    import swa_pkg::*;

    logic [N_STAGES-1:0]         mp_live;
    logic                        mp_any;
    logic [IDX_W-1:0]            mp_pos;
    logic [IDX_W-1:0]            head;
    slot_cmd_t [N_STAGES-1:0]    cmd;

    // Mispredicts from empty stages are dropped here.
    assign mp_live = stage_mispredict & stage_valid;

    swa_oldest_pick #(.N_STAGES(N_STAGES)) u_pick (
        .head    (head),
        .req     (mp_live),
        .any     (mp_any),
        .rel_pos (mp_pos)
    );

    swa_ring_ctrl #(.N_STAGES(N_STAGES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .stage_done  (stage_done),
        .stage_valid (stage_valid),
        .mp_any      (mp_any),
        .mp_pos      (mp_pos),
        .head        (head),
        .alloc_ready (alloc_ready),
        .cmd         (cmd)
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_slot
        swa_stage_slot #(.ID_W(ID_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd[g]),
            .alloc_id (alloc_id),
            .valid    (stage_valid[g]),
            .squash   (stage_squash[g]),
            .commit   (stage_commit[g]),
            .win_id   (stage_win_id[g*ID_W +: ID_W])
        );
    end

endmodule

// File: rtl/swa_window_ring_chk.sv
module swa_window_ring_chk #(
    parameter int N_STAGES = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                alloc_valid,
    input logic                alloc_ready,
    input logic [N_STAGES-1:0] stage_done,
    input logic [N_STAGES-1:0] stage_mispredict,
    input logic [N_STAGES-1:0] stage_valid,
    input logic [N_STAGES-1:0] stage_squash,
    input logic [N_STAGES-1:0] stage_commit
);

    assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready && ((stage_done & stage_valid) == '0))
        |=> ($countones(stage_valid) == $past($countones(stage_valid)) + 1));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(stage_valid) == N_STAGES) |-> !alloc_ready);

    assert_single_commit_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_commit));

    assert_commit_needs_done_R4: assert property (@(posedge clk) disable iff (rst)
        ((stage_commit & ~$past(stage_done & stage_valid)) == '0));

    assert_commit_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ((stage_commit & stage_valid) == '0));

    assert_squash_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ((stage_squash & stage_valid) == '0));

    assert_idle_mp_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        ((stage_mispredict & stage_valid) == '0) |=> (stage_squash == '0));

endmodule

bind swa_window_ring swa_window_ring_chk #(.N_STAGES(N_STAGES)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .alloc_valid      (alloc_valid),
    .alloc_ready      (alloc_ready),
    .stage_done       (stage_done),
    .stage_mispredict (stage_mispredict),
    .stage_valid      (stage_valid),
    .stage_squash     (stage_squash),
    .stage_commit     (stage_commit)
);

// File: tb/test_swa_window_ring.sv
`timescale 1ns/1ps
module test_swa_window_ring;
    localparam int N    = 8;
    localparam int ID_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            alloc_valid = 1'b0;
    logic [ID_W-1:0] alloc_id = '0;
    logic            alloc_ready;
    logic [N-1:0]    stage_done = '0;
    logic [N-1:0]    stage_mispredict = '0;
    logic [N-1:0]    stage_valid, stage_squash, stage_commit;
    logic [N*ID_W-1:0] stage_win_id;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    // Behavioural reference ring.
    bit [N-1:0]      mv;
    logic [ID_W-1:0] mid [N];
    int              mh, mc;
    bit [N-1:0]      exp_commit, exp_squash;

    always #2.5 clk = ~clk;

    swa_window_ring #(.N_STAGES(N), .ID_W(ID_W)) i_swa_window_ring (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_id(alloc_id),
        .alloc_ready(alloc_ready), .stage_done(stage_done),
        .stage_mispredict(stage_mispredict), .stage_valid(stage_valid),
        .stage_squash(stage_squash), .stage_commit(stage_commit),
        .stage_win_id(stage_win_id)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ID_W-1:0] slot_id(input int s);
        return stage_win_id[s*ID_W +: ID_W];
    endfunction

    // One cycle: drive at falling edge, check ready, advance model, compare.
    task automatic step(input bit av, input logic [ID_W-1:0] id,
                        input bit [N-1:0] dn, input bit [N-1:0] mp);
        bit exp_ready, cfire;
        int mpk, newc, s;
        alloc_valid = av; alloc_id = id; stage_done = dn; stage_mispredict = mp;
        #1;
        exp_ready = (mc < N) && ((mp & mv) == '0);
        check("R3 alloc_ready", alloc_ready, exp_ready);
        exp_commit = '0; exp_squash = '0;
        cfire = (mc > 0) && dn[mh];
        mpk = -1;
        for (int k = 0; k < mc; k++) begin
            s = (mh + k) % N;
            if (mp[s] && mpk < 0) mpk = k;
        end
        newc = mc;
        if (mpk >= 0) begin
            for (int k = mpk + 1; k < mc; k++) begin
                s = (mh + k) % N;
                exp_squash[s] = 1'b1; mv[s] = 1'b0;
            end
            newc = mpk + 1;
        end
        if (cfire) begin
            exp_commit[mh] = 1'b1; mv[mh] = 1'b0;
            mh = (mh + 1) % N; newc--;
        end
        if (av && exp_ready) begin
            s = (mh + newc) % N;
            mv[s] = 1'b1; mid[s] = id; newc++;
        end
        mc = newc;
        @(posedge clk);
        @(negedge clk);
        check("R2 stage_valid", stage_valid, mv);
        check("R4 stage_commit", stage_commit, exp_commit);
        check("R6 stage_squash", stage_squash, exp_squash);
        for (int i = 0; i < N; i++) begin
            if (mv[i]) check("R2 stage_win_id", slot_id(i), mid[i]);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        mv = '0; mh = 0; mc = 0;
        for (int i = 0; i < N; i++) mid[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", stage_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", stage_valid, 0);
        check("R1 commit after reset", stage_commit, 0);
        check("R1 squash after reset", stage_squash, 0);
        check("R1 ready after reset", alloc_ready, 1);

        // Fill the ring.
        for (int i = 0; i < N; i++) step(1'b1, ID_W'(10 + i), '0, '0);
        check("R2 id of stage 5", slot_id(5), 15);
        check("R3 full ready", alloc_ready, 0);
        step(1'b1, 8'd99, 8'h10, '0);          // full and a non-head done
        check("R4 non-head done", stage_commit, 0);
        check("R3 rejected alloc", stage_valid, 8'hFF);
        step(1'b0, '0, 8'h01, '0);
        check("R4 head commit", stage_commit, 8'h01);
        check("R4 head cleared", stage_valid, 8'hFE);
        step(1'b0, '0, '0, 8'h28);             // stages 5 and 3 mispredict
        check("R8 oldest wins squash", stage_squash, 8'hF0);
        check("R8 oldest wins valid", stage_valid, 8'h0E);
        step(1'b1, 8'd50, '0, '0);
        check("R7 tail after truncate", stage_valid, 8'h1E);
        check("R7 id at stage 4", slot_id(4), 50);
        step(1'b0, '0, 8'h02, 8'h04);          // commit head 1, mispredict 2
        check("R9 commit", stage_commit, 8'h02);
        check("R9 squash", stage_squash, 8'h18);
        check("R9 valid", stage_valid, 8'h04);
        step(1'b0, '0, '0, 8'h40);             // stage 6 empty
        check("R10 idle mispredict", stage_squash, 0);
        check("R10 valid kept", stage_valid, 8'h04);
        step(1'b0, '0, 8'h04, '0);
        step(1'b0, '0, 8'hFF, '0);             // empty ring
        check("R5 empty commit", stage_commit, 0);
        for (int i = 0; i < N; i++) step(1'b1, ID_W'(60 + i), '0, '0);
        check("R11 wrap full", stage_valid, 8'hFF);
        check("R11 id at stage 0", slot_id(0), 65);
        check("R11 id at stage 7", slot_id(7), 64);

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            bit [N-1:0] dn, mp;
            dn = '0; mp = '0;
            for (int i = 0; i < N; i++) dn[i] = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 9) == 0) mp[$urandom_range(0, N-1)] = 1'b1;
            if ($urandom_range(0, 29) == 0) mp[$urandom_range(0, N-1)] = 1'b1;
            step($urandom_range(0, 9) < 7, ID_W'($urandom), dn, mp);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule